// File: doc/BRIEF.md
# Configurable Coarse-Grained Fabric Cell

This block is one tile of a virtual reconfigurable datapath laid over ordinary logic. The tile holds a single 16-bit arithmetic unit that can add, subtract, form an absolute difference, or multiply. Two operand multiplexers choose the unit's inputs from the four 16-bit routing tracks that enter the tile: two horizontal and two vertical. Four outgoing tracks, two horizontal and two vertical, each come from a registered multiplexer. That multiplexer can forward an incoming track, carry the unit's result, or drive zero. Each operand has its own realignment line of up to seven added cycles. Nets that reach the tile out of step can therefore be brought back into line.

All selects, the delays and the operation sit in one 24-bit configuration word. The word is loaded serially. While `cfg_en` is high, one bit enters per clock. The bit that falls off the far end appears on `cfg_out`, so tiles can be chained into a single scan path for the whole fabric. During loading, the datapath freezes. Afterwards, the configuration stays fixed until the next load.

Top module: `fabric_tile`

## Requirements
- R1: While `rst_n` is low, all outgoing tracks and `cfg_out` are zero, and every pipeline and configuration register is cleared.
- R2: On each clock with `cfg_en` high, `cfg_in` enters bit 0 of the 24-bit configuration word and every other bit moves up one place. `cfg_out` always shows bit 23, so a word sent most-significant bit first ends up in place after 24 clocks.
- R3: While `cfg_en` is high, no datapath register changes and the outgoing tracks hold their values. While `cfg_en` is low, the configuration word and `cfg_out` do not change, whatever `cfg_in` does.
- R4: Configuration word layout: [1:0] operation, [3:2] operand A source, [5:4] operand B source, [8:6] A delay, [11:9] B delay, [14:12] / [17:15] / [20:18] / [23:21] sources of `row_out` lane 0, `row_out` lane 1, `col_out` lane 0 and `col_out` lane 1.
- R5: Operand source code 0 selects `row_in` lane 0, 1 selects `row_in` lane 1, 2 selects `col_in` lane 0, and 3 selects `col_in` lane 1 (lane 0 is bits 15:0).
- R6: Operation 00 produces A+B modulo 2^16.
- R7: Operation 01 produces A−B modulo 2^16.
- R8: Operation 10 produces |A−B|, treating both operands as unsigned.
- R9: Operation 11 produces the low 16 bits of the unsigned product A×B.
- R10: A delay code d (0..7) adds exactly d clocks to that operand's path; code 0 adds none.
- R11: Outgoing source code 0..3 forwards the incoming track with that number (R5 numbering) one clock later. Code 4 carries the result, which reaches the outgoing track two clocks after the operands when both delays are 0. Codes 5..7 drive zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Configuration shift enable; freezes the datapath |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out to the next tile |
| row_in | input | 32 | Two incoming horizontal tracks, lane 0 in bits 15:0 |
| col_in | input | 32 | Two incoming vertical tracks, lane 0 in bits 15:0 |
| row_out | output | 32 | Two registered outgoing horizontal tracks |
| col_out | output | 32 | Two registered outgoing vertical tracks |

## Verification
The hardest cases to reach from the ports are the realignment taps. A delay only shows up as the cycle in which a step on an operand arrives at an outgoing track. That track is two register stages after the delay line. The stimulus holds one operand at zero and steps the other once. It then checks the output in the cycle just before the expected arrival and again at the arrival, for a middle delay code and for the largest one. The scan chain is checked by shifting a loaded word back out and comparing it bit by bit. The freeze is checked by changing the tracks while a shift is in progress.

// File: rtl/fabric_tile.sv
module fabric_tile #(
  parameter int W      = 16,
  parameter int MAXDLY = 7,
  parameter int OSEL   = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_in,
  output logic         cfg_out,
  input  logic [2*W-1:0] row_in,
  input  logic [2*W-1:0] col_in,
  output logic [2*W-1:0] row_out,
  output logic [2*W-1:0] col_out
);
  localparam int DSEL  = $clog2(MAXDLY + 1);
  localparam int SA_LO = 2;
  localparam int SB_LO = 4;
  localparam int DA_LO = 6;
  localparam int DB_LO = DA_LO + DSEL;
  localparam int O_LO  = DB_LO + DSEL;
  localparam int CFGW  = O_LO + 4 * OSEL;

  logic [CFGW-1:0] cfg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg <= '0;
    else if (cfg_en) cfg <= {cfg[CFGW-2:0], cfg_in};

  assign cfg_out = cfg[CFGW-1];

  wire [1:0]      mode  = cfg[1:0];
  wire [1:0]      sel_a = cfg[SA_LO +: 2];
  wire [1:0]      sel_b = cfg[SB_LO +: 2];
  wire [DSEL-1:0] dly_a = cfg[DA_LO +: DSEL];
  wire [DSEL-1:0] dly_b = cfg[DB_LO +: DSEL];

  logic [W-1:0] trk [4];
  assign trk[0] = row_in[W-1:0];
  assign trk[1] = row_in[2*W-1:W];
  assign trk[2] = col_in[W-1:0];
  assign trk[3] = col_in[2*W-1:W];

  wire [W-1:0] op_a = trk[sel_a];
  wire [W-1:0] op_b = trk[sel_b];

  logic [W-1:0] line_a [MAXDLY];
  logic [W-1:0] line_b [MAXDLY];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < MAXDLY; k++) begin
        line_a[k] <= '0;
        line_b[k] <= '0;
      end
    end else if (!cfg_en) begin
      line_a[0] <= op_a;
      line_b[0] <= op_b;
      for (int k = 1; k < MAXDLY; k++) begin
        line_a[k] <= line_a[k-1];
        line_b[k] <= line_b[k-1];
      end
    end

  wire [DSEL-1:0] tap_a = dly_a - 1'b1;
  wire [DSEL-1:0] tap_b = dly_b - 1'b1;
  wire [W-1:0] a = (dly_a == '0) ? op_a : line_a[tap_a];
  wire [W-1:0] b = (dly_b == '0) ? op_b : line_b[tap_b];

  logic [W-1:0] res_d, res_q;

  always_comb
    case (mode)
      2'b00:   res_d = a + b;
      2'b01:   res_d = a - b;
      2'b10:   res_d = (a >= b) ? a - b : b - a;
      default: res_d = a * b;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       res_q <= '0;
    else if (!cfg_en) res_q <= res_d;

  logic [OSEL-1:0] osel [4];
  logic [W-1:0]    oq   [4];

  for (genvar j = 0; j < 4; j++) begin : g_out
    assign osel[j] = cfg[O_LO + j*OSEL +: OSEL];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        oq[j] <= '0;
      else if (!cfg_en)
        oq[j] <= (osel[j] < 4) ? trk[osel[j][1:0]] :
                 (osel[j] == 4) ? res_q : '0;
  end

  assign row_out = {oq[1], oq[0]};
  assign col_out = {oq[3], oq[2]};

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_out == $past(cfg[CFGW-2]));

  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_out));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> ($stable(row_out) && $stable(col_out)));

  assert_absdiff_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && mode == 2'b10) |=>
      res_q <= (($past(a) > $past(b)) ? $past(a) : $past(b)));

  assert_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && osel[0] == 0) |=> row_out[W-1:0] == $past(row_in[W-1:0]));

  assert_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && osel[2] >= 5) |=> col_out[W-1:0] == '0);
endmodule

// File: tb/tb_fabric_tile.sv
`timescale 1ns/1ps
module tb_fabric_tile;
  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_in = 0;
  logic [31:0] row_in = 0, col_in = 0;
  logic cfg_out;
  logic [31:0] row_out, col_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  fabric_tile dut (.clk, .rst_n, .cfg_en, .cfg_in, .cfg_out,
                   .row_in, .col_in, .row_out, .col_out);

  always #4 clk = ~clk;

  // {op, A, B, expected}
  localparam logic [49:0] VEC [9] = '{
    {2'b00, 16'h1234, 16'h0F0F, 16'h2143},  // R6
    {2'b00, 16'hFFFF, 16'h0002, 16'h0001},  // R6 wrap
    {2'b01, 16'h0005, 16'h0007, 16'hFFFE},  // R7 borrow
    {2'b01, 16'h8000, 16'h0001, 16'h7FFF},  // R7
    {2'b10, 16'h0005, 16'h0007, 16'h0002},  // R8 b>a
    {2'b10, 16'h0100, 16'h00FF, 16'h0001},  // R8 a>b
    {2'b11, 16'h0100, 16'h0100, 16'h0000},  // R9 truncation
    {2'b11, 16'h0012, 16'h0034, 16'h03A8},  // R9
    {2'b11, 16'hFFFF, 16'hFFFF, 16'h0001}   // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] cw(input logic [1:0] m, sa, sb,
                                     input logic [2:0] da, db, o0, o1, o2, o3);
    return {o3, o2, o1, o0, db, da, sb, sa, m};
  endfunction

  task automatic load(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1;
      cfg_in = w[i];
    end
    @(negedge clk);
    cfg_en = 0;
    cfg_in = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [23:0] w, seen;
    row_in = 32'hAAAA_5555;
    col_in = 32'h1234_4321;
    tick(3);
    chk("R1 row_out in reset", row_out, 0);
    chk("R1 col_out in reset", col_out, 0);
    chk("R1 cfg_out in reset", {31'd0, cfg_out}, 0);
    rst_n = 1;
    tick(2);

    // vector table: A=row lane0, B=col lane0, row_out0=result, row_out1=pass row0,
    // col_out0=zero, col_out1=pass col1
    foreach (VEC[v]) begin
      load(cw(VEC[v][49:48], 2'd0, 2'd2, 3'd0, 3'd0, 3'd4, 3'd0, 3'd5, 3'd3));
      row_in = {16'h0BAD, VEC[v][47:32]};
      col_in = {16'h7E57 + 16'(v), VEC[v][31:16]};
      tick(2);
      chk($sformatf("R6-9 vec%0d result", v), {16'd0, row_out[15:0]}, {16'd0, VEC[v][15:0]});
    end
    chk("R11 pass row0 to row_out1", {16'd0, row_out[31:16]}, {16'd0, row_in[15:0]});
    chk("R11 code5 zero on col_out0", {16'd0, col_out[15:0]}, 0);
    chk("R11 pass col1 to col_out1", {16'd0, col_out[31:16]}, {16'd0, col_in[31:16]});

    // R11 latencies: pass one clock, result two clocks
    row_in = 32'h0000_0010;
    col_in = 32'h0000_0001;
    load(cw(2'b00, 2'd0, 2'd2, 3'd0, 3'd0, 3'd4, 3'd0, 3'd6, 3'd7));
    tick(3);
    row_in = 32'h0000_0020;
    tick(1);
    chk("R11 pass after 1 clk", {16'd0, row_out[31:16]}, 32'h20);
    chk("R11 result not before 2 clk", {16'd0, row_out[15:0]}, 32'h11);
    tick(1);
    chk("R11 result after 2 clk", {16'd0, row_out[15:0]}, 32'h21);
    chk("R11 codes 6,7 zero", col_out, 0);

    // R5: operand sources row lane1 and col lane1
    row_in = 32'h0300_FFFF;
    col_in = 32'h0040_EEEE;
    load(cw(2'b00, 2'd1, 2'd3, 3'd0, 3'd0, 3'd4, 3'd0, 3'd0, 3'd0));
    tick(2);
    chk("R5 row1+col1", {16'd0, row_out[15:0]}, 32'h0340);

    // R10: delay 3 on A, B zero
    row_in = 0;
    col_in = 0;
    load(cw(2'b01, 2'd0, 2'd2, 3'd3, 3'd0, 3'd4, 3'd0, 3'd0, 3'd0));
    tick(10);
    row_in = 32'h0000_0050;
    tick(4);
    chk("R10 delay3 not yet", {16'd0, row_out[15:0]}, 0);
    tick(1);
    chk("R10 delay3 arrives", {16'd0, row_out[15:0]}, 32'h50);

    // R10: delay 7 on B, subtract shows the step late
    row_in = 0;
    col_in = 0;
    load(cw(2'b01, 2'd0, 2'd2, 3'd0, 3'd7, 3'd4, 3'd0, 3'd0, 3'd0));
    tick(10);
    col_in = 32'h0000_0001;
    tick(8);
    chk("R10 delay7 not yet", {16'd0, row_out[15:0]}, 0);
    tick(1);
    chk("R10 delay7 arrives", {16'd0, row_out[15:0]}, 32'hFFFF);

    // R3: datapath frozen while shifting
    row_in = 32'h0000_0003;
    col_in = 32'h0000_0004;
    load(cw(2'b00, 2'd0, 2'd2, 3'd0, 3'd0, 3'd4, 3'd4, 3'd0, 3'd0));
    tick(2);
    chk("R3 setup sum", {16'd0, row_out[15:0]}, 32'h7);
    cfg_en = 1;
    cfg_in = 0;
    row_in = 32'h0000_0100;
    tick(5);
    cfg_en = 0;
    chk("R3 outputs held during shift", row_out, 32'h0007_0007);

    // R4 and R2: load a word, then shift it back out MSB first
    w = cw(2'b11, 2'd1, 2'd2, 3'd5, 3'd6, 3'd4, 3'd1, 3'd7, 3'd5);
    load(w);
    seen = 0;
    seen[23] = cfg_out;
    for (int i = 22; i >= 0; i--) begin
      cfg_en = 1;
      cfg_in = 0;
      @(negedge clk);
      seen[i] = cfg_out;
    end
    cfg_en = 0;
    chk("R2 chain shifts word back out", {8'd0, seen}, {8'd0, w});

    // R3: configuration ignores cfg_in while cfg_en low
    load(cw(2'b00, 2'd0, 2'd2, 3'd0, 3'd0, 3'd4, 3'd0, 3'd0, 3'd4));
    for (int i = 0; i < 6; i++) begin
      cfg_in = i[0];
      @(negedge clk);
    end
    cfg_in = 0;
    chk("R3 cfg_out stable when disabled", {31'd0, cfg_out}, 1);
    row_in = 32'h0000_0002;
    col_in = 32'h0000_0005;
    tick(2);
    chk("R4 config unchanged, sum still selected", {16'd0, row_out[15:0]}, 32'h7);

    finish_run();
  end
endmodule